// File: doc/BRIEF.md
# Two-Level Debug Clock Selector

This block steers one of many on-chip clocks to a single observation output, so that a frequency counter or a scope probe can look at any of them through one pin. The choice is made in two levels. A primary selector takes either one of its local clocks or the output of one of several secondary selectors. Each secondary selector picks among its own group of sources, divides the result by a programmable integer and, when it is built with one, gates it with its own enable. The primary level then divides its chosen signal again and gates it with an output enable.

All clocks are modelled as single-bit levels that change slower than the block clock. Each divide stage is a small state machine with three states. In `ST_BYPASS` it passes its input straight through, and it stays there while its ratio field is 0. It leaves `ST_BYPASS` for `ST_HIGH` on the first input rising edge after the ratio becomes non-zero. It moves from `ST_HIGH` to `ST_LOW` after ceil(N/2) input rising edges, and from `ST_LOW` back to `ST_HIGH` after floor(N/2) input rising edges. From either `ST_HIGH` or `ST_LOW` it returns to `ST_BYPASS` as soon as the ratio field reads 0.

Software programs the selectors and dividers through a plain register write port. It reads back the total factor between the chosen source's original frequency and the debug output, so that it can scale a measured rate back to the source rate.

Top module: `dbg_clk_tree`

## Requirements
- R1: After reset every configuration field is 0. This means primary choice 0, all dividers at divide-by-1, the output enable clear and the secondary enable clear. In this state `dbg_clk` is low and `div_total` equals the prescale factor of local source 0, which is 1 by default.
- R2: The primary choice is the field at bits [PSEL_LSB+PSEL_W-1:PSEL_LSB] of a write to address 0x00. With the defaults these are bits [6:4]. A write changes only this field, and the other data bits have no effect. Codes 0 to NUM_LOCAL-1 pick `local_clk[code]`. Code NUM_LOCAL+k picks secondary selector k. Any higher code drives a constant-low source, and `div_total` then reads 0.
- R3: Every divider field holds the wanted ratio N minus 1. A write to 0x01 sets the primary divider from bits [DIV_W-1:0]. A write to 0x11+4k sets the divider of secondary k.
- R4: A stage with N = 1 passes its input through unchanged. A stage with N ≥ 2 gives an output whose period is N input periods. Its high phase lasts ceil(N/2) input periods and its low phase floor(N/2) input periods, so even N gives a 50% duty cycle and odd N gives a high phase one input period longer than the low phase.
- R5: `div_total` equals the primary factor (primary divider + 1) multiplied by the factor of the chosen source. For a secondary source that factor is (its divider + 1). It follows a configuration write at once.
- R6: Bit 0 of a write to 0x02 is the output enable. While it is clear, `dbg_clk` stays low.
- R7: Bit 0 of a write to 0x12+4k is the enable of secondary k. When k is built with a gate (SEC_HAS_GATE[k] = 1), a clear enable holds that path low. When k is built without a gate, its path always runs and writes to that address have no effect.
- R8: Each local source may sit behind a fixed prescaler, set by the PRE_W-bit field k of LOCAL_PRE (defaults 1, 2, 1, 4). This factor is part of `div_total` when that local source is chosen.
- R9: Writing the primary registers, or choosing a local source, leaves every secondary setting unchanged. Returning to a secondary selector gives the output it had before.
- R10: A write to 0x10+4k sets the source choice of secondary k from bits [SSEL_W-1:0]. Code j picks `sec_src[k*SEC_SRCS+j]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all sources are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| local_clk | input | NUM_LOCAL | Sources local to the primary level |
| sec_src | input | NUM_SEC*SEC_SRCS | Sources of the secondary selectors, grouped by selector |
| dbg_clk | output | 1 | Divided, gated debug clock |
| div_total | output | TOT_W | Total division from the chosen source to `dbg_clk` |

## Verification
The bench measures the high and low run lengths of `dbg_clk` for odd and even ratios, both through one stage and through two stages in cascade. A divider that mishandled the N-1 encoding would show the wrong period, and one that split odd ratios the wrong way would show swapped or equal phases. It drives junk into the bits around the primary select field, and uses out-of-range select codes. A decoder that was too wide would then pick the wrong source or a non-zero factor. It disables the gated secondary path and tries to disable the ungated one, and it switches to a local source and back. A wrong gate variant, or a write that disturbed the secondary settings, would change what `dbg_clk` shows after the return.

// File: rtl/dct_pkg.sv
package dct_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    // Primary registers
    localparam logic [ADDR_W-1:0] A_PSEL     = 8'h00;
    localparam logic [ADDR_W-1:0] A_PDIV     = 8'h01;
    localparam logic [ADDR_W-1:0] A_PEN      = 8'h02;
    // Secondary register windows: base + k*stride + offset
    localparam logic [ADDR_W-1:0] A_SEC_BASE = 8'h10;
    localparam int                SEC_STRIDE = 4;
    localparam logic [ADDR_W-1:0] OFS_SEL    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIV    = 8'h01;
    localparam logic [ADDR_W-1:0] OFS_EN     = 8'h02;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_HIGH   = 2'd1,
        ST_LOW    = 2'd2
    } div_state_e;

endpackage

// File: rtl/dct_div.sv
module dct_div
    import dct_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_i,
    input  logic [DIV_W-1:0] ratio_i,
    output logic             div_o
);
    localparam int CW = DIV_W + 1;

    div_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] n_full, hi_len, lo_len;
    logic          src_d, rise;

    assign n_full = {1'b0, ratio_i} + CW'(1);
    assign hi_len = (n_full + CW'(1)) >> 1;
    assign lo_len = n_full >> 1;
    assign rise   = src_i & ~src_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_BYPASS;
            cnt_q <= '0;
            src_d <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            src_d <= src_i;
        end
    end

    // transitions
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (ratio_i == '0) begin
            st_d  = ST_BYPASS;
            cnt_d = '0;
        end else if (rise) begin
            unique case (st_q)
                ST_BYPASS: begin
                    st_d  = ST_HIGH;
                    cnt_d = '0;
                end
                ST_HIGH: begin
                    if (cnt_q + CW'(1) >= hi_len) begin
                        st_d  = ST_LOW;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                ST_LOW: begin
                    if (cnt_q + CW'(1) >= lo_len) begin
                        st_d  = ST_HIGH;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                default: begin
                    st_d  = ST_BYPASS;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_HIGH: div_o = 1'b1;
            ST_LOW:  div_o = 1'b0;
            default: div_o = src_d;
        endcase
    end

endmodule

// File: rtl/dct_leaf.sv
module dct_leaf #(
    parameter  int SRCS   = 4,
    parameter  int DIV_W  = 4,
    localparam int SSEL_W = (SRCS > 1) ? $clog2(SRCS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRCS-1:0]   src_i,
    input  logic [SSEL_W-1:0] sel_i,
    input  logic [DIV_W-1:0]  ratio_i,
    input  logic              en_i,
    output logic              clk_o
);
    logic [(2**SSEL_W)-1:0] pool;
    logic                   picked, divided;

    always_comb begin
        pool           = '0;
        pool[SRCS-1:0] = src_i;
        picked         = pool[sel_i];
    end

    dct_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (picked),
        .ratio_i (ratio_i),
        .div_o   (divided)
    );

    assign clk_o = divided & en_i;

endmodule

// File: rtl/dct_cfg.sv
module dct_cfg
    import dct_pkg::*;
#(
    parameter int             NUM_SEC      = 2,
    parameter int             SSEL_W       = 2,
    parameter int             PSEL_W       = 3,
    parameter int             PSEL_LSB     = 4,
    parameter int             DIV_W        = 4,
    parameter logic [NUM_SEC-1:0] SEC_HAS_GATE = 2'b01
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [PSEL_W-1:0]         psel_o,
    output logic [DIV_W-1:0]          pdiv_o,
    output logic                      pen_o,
    output logic [NUM_SEC*SSEL_W-1:0] ssel_o,
    output logic [NUM_SEC*DIV_W-1:0]  sdiv_o,
    output logic [NUM_SEC-1:0]        sen_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psel_o <= '0;
            pdiv_o <= '0;
            pen_o  <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == A_PSEL) psel_o <= wr_data[PSEL_LSB +: PSEL_W];
            if (wr_addr == A_PDIV) pdiv_o <= wr_data[DIV_W-1:0];
            if (wr_addr == A_PEN)  pen_o  <= wr_data[0];
        end
    end

    for (genvar k = 0; k < NUM_SEC; k++) begin : g_sec
        localparam logic [ADDR_W-1:0] K_BASE = A_SEC_BASE + ADDR_W'(k * SEC_STRIDE);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ssel_o[k*SSEL_W +: SSEL_W] <= '0;
                sdiv_o[k*DIV_W +: DIV_W]   <= '0;
            end else if (wr_en) begin
                if (wr_addr == K_BASE + OFS_SEL) ssel_o[k*SSEL_W +: SSEL_W] <= wr_data[SSEL_W-1:0];
                if (wr_addr == K_BASE + OFS_DIV) sdiv_o[k*DIV_W +: DIV_W]   <= wr_data[DIV_W-1:0];
            end
        end

        if (SEC_HAS_GATE[k]) begin : g_gate
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                 sen_o[k] <= 1'b0;
                else if (wr_en && wr_addr == K_BASE + OFS_EN) sen_o[k] <= wr_data[0];
            end
        end else begin : g_open
            assign sen_o[k] = 1'b1;
        end
    end

endmodule

// File: rtl/dbg_clk_tree.sv
module dbg_clk_tree
    import dct_pkg::*;
#(
    parameter  int                       NUM_LOCAL    = 4,
    parameter  int                       NUM_SEC      = 2,
    parameter  int                       SEC_SRCS     = 4,
    parameter  int                       DIV_W        = 4,
    parameter  int                       PRE_W        = 4,
    parameter  int                       PSEL_LSB     = 4,
    parameter  logic [NUM_LOCAL*PRE_W-1:0] LOCAL_PRE  = 16'h4121,
    parameter  logic [NUM_SEC-1:0]       SEC_HAS_GATE = 2'b01,
    localparam int                       N_PRIM       = NUM_LOCAL + NUM_SEC,
    localparam int                       PSEL_W       = $clog2(N_PRIM),
    localparam int                       SSEL_W       = (SEC_SRCS > 1) ? $clog2(SEC_SRCS) : 1,
    localparam int                       BASE_W       = (PRE_W > DIV_W + 1) ? PRE_W : DIV_W + 1,
    localparam int                       TOT_W        = BASE_W + DIV_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_wr_en,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [DATA_W-1:0]           cfg_wdata,
    input  logic [NUM_LOCAL-1:0]        local_clk,
    input  logic [NUM_SEC*SEC_SRCS-1:0] sec_src,
    output logic                        dbg_clk,
    output logic [TOT_W-1:0]            div_total
);
    logic [PSEL_W-1:0]         psel_q;
    logic [DIV_W-1:0]          pdiv_q;
    logic                      pen_q;
    logic [NUM_SEC*SSEL_W-1:0] ssel_flat;
    logic [NUM_SEC*DIV_W-1:0]  sdiv_flat;
    logic [NUM_SEC-1:0]        sen_vec;
    logic [NUM_SEC-1:0]        leaf_clk;
    logic [(2**PSEL_W)-1:0]    cand;
    logic                      prim_src, prim_div;
    logic [BASE_W-1:0]         base_fac;
    logic [DIV_W:0]            prim_fac;

    dct_cfg #(
        .NUM_SEC      (NUM_SEC),
        .SSEL_W       (SSEL_W),
        .PSEL_W       (PSEL_W),
        .PSEL_LSB     (PSEL_LSB),
        .DIV_W        (DIV_W),
        .SEC_HAS_GATE (SEC_HAS_GATE)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .psel_o  (psel_q),
        .pdiv_o  (pdiv_q),
        .pen_o   (pen_q),
        .ssel_o  (ssel_flat),
        .sdiv_o  (sdiv_flat),
        .sen_o   (sen_vec)
    );

    for (genvar k = 0; k < NUM_SEC; k++) begin : g_leaf
        dct_leaf #(.SRCS(SEC_SRCS), .DIV_W(DIV_W)) u_leaf (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (sec_src[k*SEC_SRCS +: SEC_SRCS]),
            .sel_i   (ssel_flat[k*SSEL_W +: SSEL_W]),
            .ratio_i (sdiv_flat[k*DIV_W +: DIV_W]),
            .en_i    (sen_vec[k]),
            .clk_o   (leaf_clk[k])
        );
    end

    // primary choice: local sources first, then secondaries, rest tied low
    always_comb begin
        cand             = '0;
        cand[N_PRIM-1:0] = {leaf_clk, local_clk};
        prim_src         = cand[psel_q];
    end

    dct_div #(.DIV_W(DIV_W)) u_pdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (prim_src),
        .ratio_i (pdiv_q),
        .div_o   (prim_div)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dbg_clk <= 1'b0;
        else        dbg_clk <= pen_q & prim_div;
    end

    // total division readback
    always_comb begin
        base_fac = '0;
        for (int i = 0; i < NUM_LOCAL; i++)
            if (psel_q == PSEL_W'(i)) base_fac = BASE_W'(LOCAL_PRE[i*PRE_W +: PRE_W]);
        for (int k = 0; k < NUM_SEC; k++)
            if (psel_q == PSEL_W'(NUM_LOCAL + k))
                base_fac = BASE_W'({1'b0, sdiv_flat[k*DIV_W +: DIV_W]}) + BASE_W'(1);
        prim_fac  = {1'b0, pdiv_q} + (DIV_W+1)'(1);
        div_total = TOT_W'(base_fac) * TOT_W'(prim_fac);
    end

endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
    parameter  int NUM_LOCAL = 4,
    parameter  int NUM_SEC   = 2,
    parameter  int SEC_SRCS  = 4,
    parameter  int DIV_W     = 4,
    parameter  int PRE_W     = 4,
    parameter  int PSEL_LSB  = 4,
    localparam int N_PRIM    = NUM_LOCAL + NUM_SEC,
    localparam int PSEL_W    = $clog2(N_PRIM),
    localparam int SSEL_W    = (SEC_SRCS > 1) ? $clog2(SEC_SRCS) : 1,
    localparam int BASE_W    = (PRE_W > DIV_W + 1) ? PRE_W : DIV_W + 1,
    localparam int TOT_W     = BASE_W + DIV_W + 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_wr_en,
    input logic [7:0]                cfg_addr,
    input logic [31:0]               cfg_wdata,
    input logic [PSEL_W-1:0]         psel_q,
    input logic [DIV_W-1:0]          pdiv_q,
    input logic                      pen_q,
    input logic [NUM_SEC*SSEL_W-1:0] ssel_flat,
    input logic [NUM_SEC*DIV_W-1:0]  sdiv_flat,
    input logic                      dbg_clk,
    input logic [TOT_W-1:0]          div_total
);

    a_r2_field_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == 8'h00) |=> (psel_q == $past(cfg_wdata[PSEL_LSB +: PSEL_W])));

    a_r3_div_field: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == 8'h01) |=> (pdiv_q == $past(cfg_wdata[DIV_W-1:0])));

    a_r5_total_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (psel_q < PSEL_W'(N_PRIM)) |-> (div_total != '0));

    a_r6_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pen_q |=> !dbg_clk);

    a_r9_sec_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr < 8'h10) |=> ($stable(ssel_flat) && $stable(sdiv_flat)));

endmodule

bind dbg_clk_tree dct_checker #(
    .NUM_LOCAL (NUM_LOCAL),
    .NUM_SEC   (NUM_SEC),
    .SEC_SRCS  (SEC_SRCS),
    .DIV_W     (DIV_W),
    .PRE_W     (PRE_W),
    .PSEL_LSB  (PSEL_LSB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .psel_q    (psel_q),
    .pdiv_q    (pdiv_q),
    .pen_q     (pen_q),
    .ssel_flat (ssel_flat),
    .sdiv_flat (sdiv_flat),
    .dbg_clk   (dbg_clk),
    .div_total (div_total)
);

// File: tb/dbg_clk_tree_tb.sv
module dbg_clk_tree_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  local_clk = '0;
    logic [7:0]  sec_src = '0;
    logic        dbg_clk;
    logic [9:0]  div_total;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int cnt_l [4] = '{default: 0};
    int cnt_s [8] = '{default: 0};

    // bench model of the configuration
    int m_psel = 0, m_pdiv = 0;
    int m_ssel [2] = '{default: 0};
    int m_sdiv [2] = '{default: 0};

    dbg_clk_tree u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .local_clk (local_clk),
        .sec_src   (sec_src),
        .dbg_clk   (dbg_clk),
        .div_total (div_total)
    );

    always #5 clk = ~clk;

    // source generators: local i half period 2+i, secondary source j half period 3+j
    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (cnt_l[i] + 1 >= 2 + i) begin cnt_l[i] <= 0; local_clk[i] <= ~local_clk[i]; end
            else cnt_l[i] <= cnt_l[i] + 1;
        end
        for (int j = 0; j < 8; j++) begin
            if (cnt_s[j] + 1 >= 3 + j) begin cnt_s[j] <= 0; sec_src[j] <= ~sec_src[j]; end
            else cnt_s[j] <= cnt_s[j] + 1;
        end
    end

    function automatic int pre_of(int i);
        int pre [4] = '{1, 2, 1, 4};
        return pre[i];
    endfunction

    function automatic int exp_total();
        if (m_psel < 4) return pre_of(m_psel) * (m_pdiv + 1);
        if (m_psel < 6) return (m_sdiv[m_psel-4] + 1) * (m_pdiv + 1);
        return 0;
    endfunction

    function automatic void stage(inout int hi, inout int per, input int n);
        if (n > 1) begin
            hi  = ((n + 1) / 2) * per;
            per = per * n;
        end
    endfunction

    function automatic void exp_shape(output int hi, output int lo);
        int h, per, k;
        if (m_psel < 4) begin
            h = 2 + m_psel; hi = h; per = 2 * h;
        end else begin
            k = m_psel - 4;
            h = 3 + k * 4 + m_ssel[k]; hi = h; per = 2 * h;
            stage(hi, per, m_sdiv[k] + 1);
        end
        stage(hi, per, m_pdiv + 1);
        lo = per - hi;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic wait_lvl(input bit lvl);
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (dbg_clk == lvl) return;
        end
    endtask

    task automatic measure(output int hi, output int lo);
        repeat (600) @(negedge clk);
        wait_lvl(0); wait_lvl(1); wait_lvl(0); wait_lvl(1);
        hi = 0; lo = 0;
        while (dbg_clk && hi < 3000) begin hi++; @(negedge clk); end
        while (!dbg_clk && lo < 3000) begin lo++; @(negedge clk); end
    endtask

    task automatic count_rises(input int cycles, output int rises);
        bit prev;
        rises = 0; prev = dbg_clk;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (dbg_clk && !prev) rises++;
            prev = dbg_clk;
        end
    endtask

    task automatic shape_check(input string tag);
        int hi, lo, ehi, elo;
        exp_shape(ehi, elo);
        measure(hi, lo);
        chk(hi == ehi, {tag, " high phase"}, hi, ehi);
        chk(lo == elo, {tag, " low phase"}, lo, elo);
        chk(int'(div_total) == exp_total(), {tag, " div_total"}, int'(div_total), exp_total());
    endtask

    task automatic set_prim(input int sel, input int dv);
        m_psel = sel; m_pdiv = dv;
        wr(8'h00, 32'(sel) << 4);
        wr(8'h01, 32'(dv));
    endtask

    task automatic set_sec(input int k, input int sel, input int dv);
        m_ssel[k] = sel; m_sdiv[k] = dv;
        wr(8'h10 + 8'(4 * k), 32'(sel));
        wr(8'h11 + 8'(4 * k), 32'(dv));
    endtask

    initial begin
        int r, seed_val;
        seed_val = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(dbg_clk == 1'b0, "R1 dbg_clk low after reset", int'(dbg_clk), 0);
        chk(div_total == 10'd1, "R1 div_total after reset", int'(div_total), 1);

        // R6 output enable clear keeps output low
        count_rises(200, r);
        chk(r == 0, "R6 disabled output quiet", r, 0);
        wr(8'h02, 32'h1);
        shape_check("R4 local0 N=1 passthrough");

        // R3/R4 odd divide on local 2
        set_prim(2, 2);
        shape_check("R3 R4 local2 N=3");

        // R8 prescaler in total
        set_prim(1, 1);
        chk(div_total == 10'd4, "R8 local1 prescale 2 x div 2", int'(div_total), 4);
        set_prim(3, 0);
        chk(div_total == 10'd4, "R8 local3 prescale 4", int'(div_total), 4);

        // R2 junk around the select field: bits [6:4] = 1
        m_psel = 1; m_pdiv = 1;
        wr(8'h01, 32'h1);
        wr(8'h00, 32'hFFFF_FF9F);
        shape_check("R2 junk bits ignored, local1 N=2");

        // R2 out-of-range codes
        m_psel = 6;
        wr(8'h00, 32'h60);
        chk(div_total == 10'd0, "R2 code 6 total zero", int'(div_total), 0);
        repeat (20) @(negedge clk);
        count_rises(300, r);
        chk(r == 0, "R2 code 6 output quiet", r, 0);
        m_psel = 7;
        wr(8'h00, 32'h70);
        chk(div_total == 10'd0, "R2 code 7 total zero", int'(div_total), 0);

        // R10 secondary 0 source choice, R7 gate open
        set_sec(0, 2, 1);
        wr(8'h12, 32'h1);
        set_prim(4, 0);
        shape_check("R10 sec0 src2 N=2");

        // R7 gated secondary held low
        wr(8'h12, 32'h0);
        repeat (40) @(negedge clk);
        count_rises(300, r);
        chk(r == 0, "R7 sec0 gate clear output quiet", r, 0);

        // R7 ungated secondary ignores enable write
        set_sec(1, 1, 0);
        wr(8'h16, 32'h0);
        set_prim(5, 0);
        shape_check("R7 sec1 ungated despite enable write");

        // R9 local choice leaves secondary settings intact
        wr(8'h12, 32'h1);
        set_prim(0, 0);
        repeat (50) @(negedge clk);
        set_prim(4, 0);
        shape_check("R9 sec0 restored after local choice");

        // R5 cascade of both dividers
        set_sec(0, 2, 2);
        set_prim(4, 1);
        shape_check("R5 cascade N1=3 N2=2");

        // random mix
        for (int it = 0; it < 12; it++) begin
            set_sec(0, int'($urandom_range(3, 0)), int'($urandom_range(3, 0)));
            set_sec(1, int'($urandom_range(3, 0)), int'($urandom_range(3, 0)));
            set_prim(int'($urandom_range(5, 0)), int'($urandom_range(3, 0)));
            shape_check("R3 R4 R5 random config");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule